// File: doc/BRIEF.md
# Serial-to-Parallel LED Shift Controller

This block feeds a chain of external 8-bit serial-in, parallel-out shift registers from a small word-addressed register set. Software places up to 24 output bits in a data register and enables one, two or three 8-bit groups. On each transfer the block sends the enabled bits out on a serial data pin under a divided shift clock, starting with the most significant bit. It then raises a store pin for one shift-clock period so that the external registers move the new pattern to their outputs.

Any of the low eight cascade bits can be taken from hardware status inputs in place of the software word. Two bits can come from a modem status input, three from a first PHY status input and three from a second PHY status input. A transfer begins when software sets the update bit, or at regular intervals when an automatic refresh timer is selected. The timer runs at one of four encoded rates derived from the system clock frequency parameter.

Top module: `led_shift_ctrl`

## Requirements
- R1: After reset, control 0 (byte offset 0x00) reads 0x8000_0000. Control 1 (0x04), data 0 (0x08), data 1 (0x0C) and the access register (0x10) read 0. The store and data pins are low and the shift clock is low.
- R2: A transfer shifts 8×k bits, where k is the index (1..3) of the highest set bit in control 1 bits [2:0]. The word comes from data 0 bits [23:0], most significant enabled bit first.
- R3: When control 0 bit 26 is 1, the shift clock idles high and each data bit is held stable across a falling edge. When the bit is 0, the clock idles low and each bit is held across a rising edge.
- R4: Control 0 bit 24+j (j = 0,1) set to 1 replaces cascade bit j with modem status bit j.
- R5: Control 0 bit 27+j replaces cascade bit 2+j with PHY1 status bit j. Control 1 bit 15+j replaces cascade bit 5+j with PHY2 status bit j (j = 0..2).
- R6: Data and status bits are captured when a transfer starts. Changes made during the transfer do not affect the bits being shifted.
- R7: Writing control 0 with bit 31 = 1 starts a transfer. Bit 31 reads back 0 once that transfer has started.
- R8: An update request written during a transfer is kept and starts a second transfer after the current store pulse.
- R9: After the last bit the store pin is high for exactly 2×SHIFT_DIV clock cycles. While it is high, the data pin is low and the shift clock is at its idle level.
- R10: When control 0 bit 31 is 0 and control 1 bits [31:30] = 2'b10, transfers repeat every CLK_HZ/2, CLK_HZ/4, CLK_HZ/8 or CLK_HZ/10 cycles, for control 1 bits [24:23] = 00, 01, 10, 11 respectively.
- R11: With control 1 bits [31:30] at 00, 01 or 11, no automatic transfers occur.
- R12: Data 1 and the access register read back what was written and start no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register; only word-aligned addresses decode |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| modem_sts | input | 2 | Modem status bits for cascade bits 1..0 |
| phy1_sts | input | 3 | PHY1 status bits for cascade bits 4..2 |
| phy2_sts | input | 3 | PHY2 status bits for cascade bits 7..5 |
| sd_out | output | 1 | Serial data to the cascade |
| sck_out | output | 1 | Shift clock to the cascade |
| st_out | output | 1 | Store/latch strobe to the cascade |

## Verification
The bench rebuilds every frame from the pins by sampling the data pin on the selected clock edge. This catches three kinds of fault: a wrong bit order, a wrong group length such as counting enabled groups instead of taking the highest one, and an inverted edge, which would drop or shift bits. Status overrides are tested on mixed patterns, because a select bit routed to the wrong cascade position shows up as a changed frame word. A second update request issued mid-transfer, together with status and data changes, checks two faults: losing the pending request, and sampling late, which would corrupt the first frame. Automatic refresh intervals are measured to the exact cycle for all four rate codes. An off-by-one in the timer reload would show there, and a missing gate would show as stray transfers when the clock source is not selected.

// File: rtl/led_shift_pkg.sv
package led_shift_pkg;

   localparam int unsigned IDX_CTRL0  = 0;
   localparam int unsigned IDX_CTRL1  = 1;
   localparam int unsigned IDX_DATA0  = 2;
   localparam int unsigned IDX_DATA1  = 3;
   localparam int unsigned IDX_ACCESS = 4;

   localparam int unsigned BIT_SWU    = 31;
   localparam int unsigned BIT_FALL   = 26;
   localparam int unsigned LO_MODEM   = 24;
   localparam int unsigned LO_PHY1    = 27;
   localparam int unsigned LO_PHY2    = 15;
   localparam int unsigned LO_RATE    = 23;
   localparam int unsigned LO_TSRC    = 30;

   localparam logic [1:0] TSRC_BUS   = 2'b10;
   localparam logic [31:0] CTRL0_RST = 32'h8000_0000;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_SHIFT = 2'd1,
      SEQ_LATCH = 2'd2
   } seq_state_t;

   function automatic int unsigned refresh_period(int unsigned clk_hz, logic [1:0] code);
      case (code)
         2'b00:   return clk_hz / 2;
         2'b01:   return clk_hz / 4;
         2'b10:   return clk_hz / 8;
         default: return clk_hz / 10;
      endcase
   endfunction

endpackage

// File: rtl/led_shift_regs.sv
module led_shift_regs
   import led_shift_pkg::*;
#(
   parameter int unsigned FRAME_W  = 24,
   parameter int unsigned N_GROUPS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [4:0]          bus_addr,
   input  logic                bus_wr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic                seq_start,
   output logic                swu,
   output logic                sw_pend,
   output logic                ctrl0_wr,
   output logic                edge_fall,
   output logic [1:0]          modem_sel,
   output logic [2:0]          phy1_sel,
   output logic [2:0]          phy2_sel,
   output logic [N_GROUPS-1:0] grp_en,
   output logic [1:0]          rate_code,
   output logic [1:0]          tsrc,
   output logic [FRAME_W-1:0]  data_bits
);

   logic [31:0] ctrl0_q, ctrl1_q, data0_q, data1_q, access_q;
   logic        aligned;
   logic [2:0]  idx;

   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign idx      = bus_addr[4:2];
   assign ctrl0_wr = bus_wr && aligned && (idx == 3'(IDX_CTRL0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl0_q  <= CTRL0_RST;
         ctrl1_q  <= '0;
         data0_q  <= '0;
         data1_q  <= '0;
         access_q <= '0;
         sw_pend  <= 1'b0;
      end else begin
         if (seq_start) begin
            ctrl0_q[BIT_SWU] <= 1'b0;
            sw_pend          <= 1'b0;
         end
         if (bus_wr && aligned) begin
            case (idx)
               3'(IDX_CTRL0): begin
                  ctrl0_q <= bus_wdata;
                  if (bus_wdata[BIT_SWU]) sw_pend <= 1'b1;
               end
               3'(IDX_CTRL1):  ctrl1_q  <= bus_wdata;
               3'(IDX_DATA0):  data0_q  <= bus_wdata;
               3'(IDX_DATA1):  data1_q  <= bus_wdata;
               3'(IDX_ACCESS): access_q <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         case (idx)
            3'(IDX_CTRL0):  bus_rdata = ctrl0_q;
            3'(IDX_CTRL1):  bus_rdata = ctrl1_q;
            3'(IDX_DATA0):  bus_rdata = data0_q;
            3'(IDX_DATA1):  bus_rdata = data1_q;
            3'(IDX_ACCESS): bus_rdata = access_q;
            default:        bus_rdata = '0;
         endcase
      end
   end

   assign swu       = ctrl0_q[BIT_SWU];
   assign edge_fall = ctrl0_q[BIT_FALL];
   assign modem_sel = ctrl0_q[LO_MODEM +: 2];
   assign phy1_sel  = ctrl0_q[LO_PHY1 +: 3];
   assign phy2_sel  = ctrl1_q[LO_PHY2 +: 3];
   assign grp_en    = ctrl1_q[N_GROUPS-1:0];
   assign rate_code = ctrl1_q[LO_RATE +: 2];
   assign tsrc      = ctrl1_q[LO_TSRC +: 2];
   assign data_bits = data0_q[FRAME_W-1:0];

endmodule

// File: rtl/led_shift_src.sv
module led_shift_src #(
   parameter int unsigned FRAME_W = 24
) (
   input  logic [FRAME_W-1:0] data_bits,
   input  logic [1:0]         modem_sel,
   input  logic [1:0]         modem_sts,
   input  logic [2:0]         phy1_sel,
   input  logic [2:0]         phy1_sts,
   input  logic [2:0]         phy2_sel,
   input  logic [2:0]         phy2_sts,
   output logic [FRAME_W-1:0] word
);

   for (genvar i = 0; i < FRAME_W; i++) begin : g_bit
      if (i < 2) begin : g_modem
         assign word[i] = modem_sel[i] ? modem_sts[i] : data_bits[i];
      end else if (i < 5) begin : g_phy1
         assign word[i] = phy1_sel[i-2] ? phy1_sts[i-2] : data_bits[i];
      end else if (i < 8) begin : g_phy2
         assign word[i] = phy2_sel[i-5] ? phy2_sts[i-5] : data_bits[i];
      end else begin : g_soft
         assign word[i] = data_bits[i];
      end
   end

endmodule

// File: rtl/led_shift_timer.sv
module led_shift_timer
   import led_shift_pkg::*;
#(
   parameter int unsigned CLK_HZ = 50_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       auto_en,
   input  logic [1:0] rate_code,
   input  logic       seq_start,
   output logic       tick,
   output logic       auto_pend
);

   localparam int unsigned CNT_W = $clog2(CLK_HZ / 2 + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   assign limit = CNT_W'(refresh_period(CLK_HZ, rate_code) - 1);
   assign tick  = auto_en && (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         auto_pend <= 1'b0;
      end else begin
         if (!auto_en)  cnt_q <= '0;
         else if (tick) cnt_q <= '0;
         else           cnt_q <= cnt_q + 1'b1;

         if (seq_start) auto_pend <= 1'b0;
         if (tick)      auto_pend <= 1'b1;
      end
   end

endmodule

// File: rtl/led_shift_seq.sv
module led_shift_seq
   import led_shift_pkg::*;
#(
   parameter int unsigned FRAME_W = 24,
   parameter int unsigned HALF    = 4,
   parameter int unsigned LEN_W   = $clog2(FRAME_W + 1),
   parameter int unsigned IDX_W   = $clog2(FRAME_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_req,
   input  logic [LEN_W-1:0]   len,
   input  logic [FRAME_W-1:0] word,
   input  logic               edge_fall,
   output logic               start,
   output logic               busy,
   output logic [FRAME_W-1:0] frame_q,
   output logic               sd,
   output logic               sck,
   output logic               st
);

   localparam int unsigned DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);

   seq_state_t       state_q;
   logic [DIV_W-1:0] div_q;
   logic             phase_q;
   logic [IDX_W-1:0] idx_q;
   logic             half_end;

   assign half_end = (div_q == DIV_LAST);
   assign start    = (state_q == SEQ_IDLE) && start_req;
   assign busy     = (state_q != SEQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         div_q   <= '0;
         phase_q <= 1'b0;
         idx_q   <= '0;
         frame_q <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (start_req && (len != '0)) begin
                  frame_q <= word;
                  idx_q   <= IDX_W'(len - 1'b1);
                  div_q   <= '0;
                  phase_q <= 1'b0;
                  state_q <= SEQ_SHIFT;
               end
            end
            SEQ_SHIFT: begin
               if (half_end) begin
                  div_q   <= '0;
                  phase_q <= ~phase_q;
                  if (phase_q) begin
                     if (idx_q == '0) state_q <= SEQ_LATCH;
                     else             idx_q   <= idx_q - 1'b1;
                  end
               end else begin
                  div_q <= div_q + 1'b1;
               end
            end
            SEQ_LATCH: begin
               if (half_end) begin
                  div_q   <= '0;
                  phase_q <= ~phase_q;
                  if (phase_q) state_q <= SEQ_IDLE;
               end else begin
                  div_q <= div_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign sd  = (state_q == SEQ_SHIFT) ? frame_q[idx_q] : 1'b0;
   assign sck = ((state_q == SEQ_SHIFT) && phase_q) ^ edge_fall;
   assign st  = (state_q == SEQ_LATCH);

endmodule

// File: rtl/led_shift_ctrl.sv
module led_shift_ctrl
   import led_shift_pkg::*;
#(
   parameter int unsigned CLK_HZ    = 50_000_000,
   parameter int unsigned SHIFT_DIV = 8,
   parameter int unsigned GROUP_W   = 8,
   parameter int unsigned N_GROUPS  = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [4:0]  bus_addr,
   input  logic        bus_wr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic [1:0]  modem_sts,
   input  logic [2:0]  phy1_sts,
   input  logic [2:0]  phy2_sts,
   output logic        sd_out,
   output logic        sck_out,
   output logic        st_out
);

   localparam int unsigned FRAME_W = GROUP_W * N_GROUPS;
   localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);
   localparam int unsigned IDX_W   = $clog2(FRAME_W);

   if (N_GROUPS < 1 || N_GROUPS > 3) begin : g_bad_groups
      $error("N_GROUPS must be 1..3");
   end
   if (GROUP_W < 8 || FRAME_W > 32) begin : g_bad_width
      $error("GROUP_W must be at least 8 and the frame at most 32 bits");
   end
   if (SHIFT_DIV < 1) begin : g_bad_div
      $error("SHIFT_DIV must be at least 1");
   end
   if (CLK_HZ < 20) begin : g_bad_clk
      $error("CLK_HZ too small for the refresh rates");
   end

   logic                swu, sw_pend, ctrl0_wr, edge_fall;
   logic [1:0]          modem_sel, rate_code, tsrc;
   logic [2:0]          phy1_sel, phy2_sel;
   logic [N_GROUPS-1:0] grp_en;
   logic [FRAME_W-1:0]  data_bits, word, frame_q;
   logic [LEN_W-1:0]    len;
   logic                auto_en, tick, auto_pend;
   logic                seq_start, seq_busy;

   led_shift_regs #(.FRAME_W(FRAME_W), .N_GROUPS(N_GROUPS)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .seq_start (seq_start),
      .swu       (swu),
      .sw_pend   (sw_pend),
      .ctrl0_wr  (ctrl0_wr),
      .edge_fall (edge_fall),
      .modem_sel (modem_sel),
      .phy1_sel  (phy1_sel),
      .phy2_sel  (phy2_sel),
      .grp_en    (grp_en),
      .rate_code (rate_code),
      .tsrc      (tsrc),
      .data_bits (data_bits)
   );

   led_shift_src #(.FRAME_W(FRAME_W)) i_src (
      .data_bits (data_bits),
      .modem_sel (modem_sel),
      .modem_sts (modem_sts),
      .phy1_sel  (phy1_sel),
      .phy1_sts  (phy1_sts),
      .phy2_sel  (phy2_sel),
      .phy2_sts  (phy2_sts),
      .word      (word)
   );

   always_comb begin
      len = '0;
      for (int g = 0; g < N_GROUPS; g++) begin
         if (grp_en[g]) len = LEN_W'((g + 1) * GROUP_W);
      end
   end

   assign auto_en = !swu && (tsrc == TSRC_BUS);

   led_shift_timer #(.CLK_HZ(CLK_HZ)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .auto_en   (auto_en),
      .rate_code (rate_code),
      .seq_start (seq_start),
      .tick      (tick),
      .auto_pend (auto_pend)
   );

   led_shift_seq #(.FRAME_W(FRAME_W), .HALF(SHIFT_DIV), .LEN_W(LEN_W), .IDX_W(IDX_W)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (sw_pend || auto_pend),
      .len       (len),
      .word      (word),
      .edge_fall (edge_fall),
      .start     (seq_start),
      .busy      (seq_busy),
      .frame_q   (frame_q),
      .sd        (sd_out),
      .sck       (sck_out),
      .st        (st_out)
   );

endmodule

// File: rtl/led_shift_chk.sv
module led_shift_chk #(
   parameter int unsigned FRAME_W = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               ctrl0_wr,
   input logic               swu,
   input logic               sw_pend,
   input logic               tick,
   input logic               auto_en,
   input logic               edge_fall,
   input logic [FRAME_W-1:0] frame_q,
   input logic               sd,
   input logic               sck,
   input logic               st
);

   // R7
   swu_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !ctrl0_wr) |=> !swu);

   // R6
   frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(frame_q));

   // R9
   store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st |-> (!sd && (sck == edge_fall)));

   // R8
   pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sw_pend) |=> sw_pend);

   // R11
   tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> auto_en);

endmodule

bind led_shift_ctrl led_shift_chk #(.FRAME_W(FRAME_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (seq_start),
   .busy      (seq_busy),
   .ctrl0_wr  (ctrl0_wr),
   .swu       (swu),
   .sw_pend   (sw_pend),
   .tick      (tick),
   .auto_en   (auto_en),
   .edge_fall (edge_fall),
   .frame_q   (frame_q),
   .sd        (sd_out),
   .sck       (sck_out),
   .st        (st_out)
);

// File: tb/test_led_shift_ctrl.sv
module test_led_shift_ctrl;

   localparam int unsigned CLK_HZ    = 1000;
   localparam int unsigned SHIFT_DIV = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  modem_sts = '0;
   logic [2:0]  phy1_sts = '0;
   logic [2:0]  phy2_sts = '0;
   logic        sd_out, sck_out, st_out;

   always #10 clk = ~clk;

   led_shift_ctrl #(.CLK_HZ(CLK_HZ), .SHIFT_DIV(SHIFT_DIV)) i_led_shift_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .modem_sts(modem_sts),
      .phy1_sts(phy1_sts), .phy2_sts(phy2_sts), .sd_out(sd_out),
      .sck_out(sck_out), .st_out(st_out)
   );

   int total = 0;
   int bad   = 0;

   // pin monitor: rebuilds frames from the serial pins
   logic        mon_fall = 1'b0;
   logic [23:0] cap = '0;
   int          nbits = 0;
   logic        prev_sck = 1'b0, prev_st = 1'b0;
   logic [23:0] frame_word = '0;
   int          frame_len = 0, frame_cnt = 0;
   int          cyc = 0, last_t = 0, prev_t = 0, st_run = 0, st_width = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (mon_fall ? (prev_sck && !sck_out) : (!prev_sck && sck_out)) begin
            cap = {cap[22:0], sd_out};
            nbits++;
         end
         if (st_out && !prev_st) begin
            frame_word = cap;
            frame_len  = nbits;
            frame_cnt++;
            prev_t = last_t;
            last_t = cyc;
            cap    = '0;
            nbits  = 0;
            st_run = 0;
         end
         if (st_out) st_run++;
         if (!st_out && prev_st) st_width = st_run;
      end
      prev_sck = sck_out;
      prev_st  = st_out;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_frames(input int n, input int limit);
      for (int k = 0; k < limit && frame_cnt < n; k++) @(negedge clk);
   endtask

   typedef struct packed {
      logic [2:0]  grp;
      logic        fall;
      logic [1:0]  msel;
      logic [1:0]  msts;
      logic [2:0]  p1sel;
      logic [2:0]  p1sts;
      logic [2:0]  p2sel;
      logic [2:0]  p2sts;
      logic [23:0] data;
      logic [23:0] exp_word;
      logic [5:0]  exp_len;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{3'b001, 1'b1, 2'b00, 2'b00, 3'b000, 3'b000, 3'b000, 3'b000, 24'h0000A5, 24'h0000A5, 6'd8},
      '{3'b011, 1'b0, 2'b00, 2'b00, 3'b000, 3'b000, 3'b000, 3'b000, 24'h00C35A, 24'h00C35A, 6'd16},
      '{3'b100, 1'b0, 2'b00, 2'b00, 3'b000, 3'b000, 3'b000, 3'b000, 24'h123456, 24'h123456, 6'd24},
      '{3'b111, 1'b1, 2'b01, 2'b10, 3'b000, 3'b000, 3'b000, 3'b000, 24'hFFFFFF, 24'hFFFFFE, 6'd24},
      '{3'b001, 1'b0, 2'b11, 2'b11, 3'b111, 3'b101, 3'b010, 3'b111, 24'h000000, 24'h000057, 6'd8},
      '{3'b010, 1'b1, 2'b00, 2'b00, 3'b000, 3'b000, 3'b111, 3'b000, 24'h00FFFF, 24'h00FF1F, 6'd16}
   };

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(5'h00, r); check("R1 ctrl0", r, 32'h8000_0000);
      rd(5'h04, r); check("R1 ctrl1", r, 32'h0);
      rd(5'h08, r); check("R1 data0", r, 32'h0);
      rd(5'h0C, r); check("R1 data1", r, 32'h0);
      rd(5'h10, r); check("R1 access", r, 32'h0);
      check("R1 pins", {29'd0, sd_out, sck_out, st_out}, 32'h0);

      // R2 R3 R4 R5: vector walk
      for (int v = 0; v < NV; v++) begin
         modem_sts = VECS[v].msts;
         phy1_sts  = VECS[v].p1sts;
         phy2_sts  = VECS[v].p2sts;
         mon_fall  = VECS[v].fall;
         wr(5'h08, {8'd0, VECS[v].data});
         wr(5'h04, (32'(VECS[v].p2sel) << 15) | 32'(VECS[v].grp));
         base = frame_cnt;
         wr(5'h00, 32'h8000_0000 | (32'(VECS[v].p1sel) << 27) |
                   (32'(VECS[v].fall) << 26) | (32'(VECS[v].msel) << 24));
         wait_frames(base + 1, 400);
         check($sformatf("R2 R4 R5 vector %0d word", v), {8'd0, frame_word}, {8'd0, VECS[v].exp_word});
         check($sformatf("R2 R3 vector %0d length", v), 32'(frame_len), 32'(VECS[v].exp_len));
         repeat (6) @(negedge clk);
         // R3 idle level follows the edge select
         check($sformatf("R3 vector %0d idle sck", v), {31'd0, sck_out}, {31'd0, VECS[v].fall});
      end

      // R9 store pulse width
      check("R9 store width", 32'(st_width), 32'(2 * SHIFT_DIV));
      // R7 self-clear of the update bit
      rd(5'h00, r); check("R7 swu cleared", {31'd0, r[31]}, 32'h0);

      // R6 R8: request during a transfer, status and data change mid-frame
      modem_sts = 2'b01;
      mon_fall  = 1'b0;
      wr(5'h04, 32'h1);
      wr(5'h08, 32'hAA);
      base = frame_cnt;
      wr(5'h00, 32'h8100_0000);
      repeat (8) @(negedge clk);
      modem_sts = 2'b00;
      wr(5'h08, 32'h0F);
      wr(5'h00, 32'h8100_0000);
      wait_frames(base + 1, 400);
      check("R6 first frame sampled at start", {8'd0, frame_word}, 32'hAB);
      wait_frames(base + 2, 400);
      check("R8 pending frame count", 32'(frame_cnt - base), 32'd2);
      check("R8 pending frame word", {8'd0, frame_word}, 32'h0E);
      check("R8 back-to-back gap", 32'(last_t - prev_t), 32'(8 * 2 * SHIFT_DIV + 2 * SHIFT_DIV + 1));

      // R12 data1 and access register
      base = frame_cnt;
      wr(5'h0C, 32'hDEAD_BEEF);
      wr(5'h10, 32'h1357_9BDF);
      rd(5'h0C, r); check("R12 data1", r, 32'hDEAD_BEEF);
      rd(5'h10, r); check("R12 access", r, 32'h1357_9BDF);
      repeat (100) @(negedge clk);
      check("R12 no transfer", 32'(frame_cnt), 32'(base));

      // R10 automatic refresh rates
      for (int c = 0; c < 4; c++) begin
         int per;
         per = (c == 0) ? CLK_HZ / 2 : (c == 1) ? CLK_HZ / 4 : (c == 2) ? CLK_HZ / 8 : CLK_HZ / 10;
         wr(5'h04, 32'h1);
         base = frame_cnt;
         wr(5'h04, 32'h8000_0001 | (32'(c) << 23));
         wait_frames(base + 2, 3 * per + 200);
         check($sformatf("R10 rate code %0d period", c), 32'(last_t - prev_t), 32'(per));
      end

      // R11 other timer sources stay quiet
      wr(5'h04, 32'h4180_0001);
      base = frame_cnt;
      repeat (300) @(negedge clk);
      check("R11 source 01 quiet", 32'(frame_cnt), 32'(base));
      wr(5'h04, 32'hC180_0001);
      repeat (300) @(negedge clk);
      check("R11 source 11 quiet", 32'(frame_cnt), 32'(base));
      wr(5'h04, 32'h0180_0001);
      repeat (300) @(negedge clk);
      check("R11 source 00 quiet", 32'(frame_cnt), 32'(base));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule